// File: doc/BRIEF.md
# Dual-Mode Multiplexed Processor Bus Slave

This block connects an 8-bit processor bus, which carries address and data on the same lines, to a bank of 256 byte-wide registers. The address goes out first and is captured when the address-latch-enable input falls. Data then moves in either direction under the control of the strobes. A static mode input selects the bus style. In split mode, separate active-low read and write strobes are used. In combined mode, one active-low data strobe is used, together with a direction line that is high for a read and low for a write.

All bus inputs pass through two-flop synchronisers into the internal clock before any decode, so the processor must hold its levels for a few internal clocks. The register bank itself sits outside the block and is reached through a plain port: an address, write data with a one-cycle write pulse, and combinational read data. The shared bus is modelled as separate input, output and output-enable signals. The output enable is raised only during a qualified read and drops when chip select or the read strobe goes inactive.

Top module: `mpbus_slave`

## Requirements
- R1: The address on `ad_i` is captured when `ale_i` falls and stays on `reg_addr_o` until the next fall; every location from 0x00 to 0xFF can be reached.
- R2: With `mode_i` = 0, a low `rd_ni` requests a read and a low `wr_ni` requests a write.
- R3: With `mode_i` = 1, a low `rd_ni` is the data strobe, and `wr_ni` sets the direction: 1 means read, 0 means write. A low `wr_ni` with `rd_ni` high causes no write.
- R4: While `cs_ni` is high, the block makes no write pulse and does not raise `ad_oe_o`.
- R5: While `ale_i` is high, the block makes no write pulse and does not raise `ad_oe_o`.
- R6: `ad_oe_o` is 1 only during a qualified read. While it is 1, `ad_o` carries the contents of the latched address. Otherwise `ad_o` is 0. Both are 0 after reset.
- R7: When chip select rises, or when the read strobe ends, the block drops `ad_oe_o` and releases the bus.
- R8: Each write cycle makes exactly one single-cycle `reg_we_o` pulse. The pulse comes on the trailing edge of the strobe or on the chip-select rise, whichever is first. It carries the last byte seen on `ad_i` while the write was active.
- R9: `ad_oe_o` rises on the third rising clock edge after the read strobe is driven active. The first two edges fill the synchroniser; the third registers the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the interface flops |
| mode_i | input | 1 | Bus style: 0 split strobes, 1 strobe plus direction |
| cs_ni | input | 1 | Chip select, active low |
| ale_i | input | 1 | Address latch enable, active high |
| rd_ni | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_ni | input | 1 | Write strobe (mode 0) or direction, 0 = write (mode 1) |
| ad_i | input | 8 | Shared address/data bus, inbound |
| ad_o | output | 8 | Shared bus, outbound read data |
| ad_oe_o | output | 1 | Drive enable for the shared bus |
| reg_addr_o | output | 8 | Latched register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Single-cycle register write pulse |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |

## Verification
Assertions run on every clock and check that the output enable is never raised unless the synchronised chip select was low, address-latch-enable was low, and the read condition for the selected mode held on the previous cycle. They also check that a write pulse never lasts longer than one cycle. Some behaviour only the bench scenarios can show. These are that data really reaches the addressed register and reads back, and that the last byte on the bus is the one committed. They also cover that a chip-select rise before the strobe ends still gives exactly one write, and that no write happens with chip select high, with address-latch-enable held high, or with a direction-only transition in combined mode. The three-edge read latency is also shown only by the bench.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic {
    MODE_SPLIT   = 1'b0,
    MODE_DSTROBE = 1'b1
  } bus_mode_e;

  // synchronised control bundle; bit order matters for the sync reset value
  typedef struct packed {
    logic mode;
    logic cs_n;
    logic ale;
    logic rd_n;
    logic wr_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{mode: 1'b0, cs_n: 1'b1, ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/mpbus_sync.sv
module mpbus_sync #(
  parameter int unsigned          W       = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain[0] <= RST_VAL;
    else         chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else         chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mpbus_addr_latch.sv
module mpbus_addr_latch #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_s_i,
  input  logic [AW-1:0] ad_s_i,
  output logic [AW-1:0] addr_o
);
  logic ale_q;
  logic ale_fall;

  assign ale_fall = ale_q & ~ale_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q  <= 1'b0;
      addr_o <= '0;
    end else begin
      ale_q <= ale_s_i;
      if (ale_fall) addr_o <= ad_s_i;
    end
  end

  // R1: address only moves on a latch-enable fall
  a_r1_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_q & ~ale_s_i) |=> $stable(addr_o));
endmodule

// File: rtl/mpbus_strobe_dec.sv
module mpbus_strobe_dec
  import mpbus_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctl_t          ctl_s_i,
  input  logic [DW-1:0] ad_s_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] ad_o,
  output logic          oe_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o
);
  logic sel;
  logic rd_act, wr_act;
  logic q_rd, q_wr;
  logic armed;

  assign sel = ~ctl_s_i.cs_n & ~ctl_s_i.ale;

  always_comb begin
    unique case (bus_mode_e'(ctl_s_i.mode))
      MODE_SPLIT: begin
        rd_act = ~ctl_s_i.rd_n;
        wr_act = ~ctl_s_i.wr_n;
      end
      MODE_DSTROBE: begin
        rd_act = ~ctl_s_i.rd_n &  ctl_s_i.wr_n;
        wr_act = ~ctl_s_i.rd_n & ~ctl_s_i.wr_n;
      end
      default: begin
        rd_act = 1'b0;
        wr_act = 1'b0;
      end
    endcase
  end

  assign q_rd = sel & rd_act;
  assign q_wr = sel & wr_act;

  // read path: registered enable and data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o <= 1'b0;
      ad_o <= '0;
    end else begin
      oe_o <= q_rd;
      ad_o <= q_rd ? rdata_i : '0;
    end
  end

  // write path: arm while active, commit once when the qualified write ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed   <= 1'b0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (q_wr) begin
        armed   <= 1'b1;
        wdata_o <= ad_s_i;
      end else if (armed) begin
        armed <= 1'b0;
        we_o  <= 1'b1;
      end
    end
  end

  // R8: pulse never stretches
  a_r8_single_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  // R8: data held stable while the commit pulse is out
  a_r8_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $stable(wdata_o));
endmodule

// File: rtl/mpbus_slave.sv
module mpbus_slave
  import mpbus_pkg::*;
#(
  parameter int unsigned BW        = BUS_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          ale_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [BW-1:0] ad_i,
  output logic [BW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] reg_addr_o,
  output logic [BW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  input  logic [BW-1:0] reg_rdata_i
);
  localparam int unsigned CW = $bits(ctl_t);

  ctl_t          ctl_raw, ctl_s;
  logic [CW-1:0] ctl_s_bits;
  logic [BW-1:0] ad_s;

  assign ctl_raw = '{mode: mode_i, cs_n: cs_ni, ale: ale_i, rd_n: rd_ni, wr_n: wr_ni};

  mpbus_sync #(.W(CW), .STAGES(SYNC_DEPTH), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s_bits)
  );
  assign ctl_s = ctl_t'(ctl_s_bits);

  // bus delayed by the same depth so address and data align with the controls
  mpbus_sync #(.W(BW), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_ad_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ad_i),
    .q_o   (ad_s)
  );

  mpbus_addr_latch #(.AW(BW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_s_i(ctl_s.ale),
    .ad_s_i (ad_s),
    .addr_o (reg_addr_o)
  );

  mpbus_strobe_dec #(.DW(BW)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_s_i(ctl_s),
    .ad_s_i (ad_s),
    .rdata_i(reg_rdata_i),
    .ad_o   (ad_o),
    .oe_o   (ad_oe_o),
    .wdata_o(reg_wdata_o),
    .we_o   (reg_we_o)
  );

  a_r4_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> $past(!ctl_s.cs_n));
  a_r5_oe_needs_data_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> $past(!ctl_s.ale));
  a_r2_split_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && $past(ctl_s.mode) == MODE_SPLIT) |-> $past(!ctl_s.rd_n));
  a_r3_dstrobe_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && $past(ctl_s.mode) == MODE_DSTROBE) |-> $past(!ctl_s.rd_n && ctl_s.wr_n));
  a_r6_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_o |-> (ad_o == '0));
endmodule

// File: tb/sim_mpbus_slave.sv
module sim_mpbus_slave;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode, cs_n, ale, rd_n, wr_n;
  logic [7:0] ad_in, ad_out, reg_addr, reg_wdata, reg_rdata;
  logic       ad_oe, reg_we;

  int total = 0;
  int bad   = 0;
  int we_cnt = 0;
  logic [7:0] last_a, last_d;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  bit done = 0;

  always #5 clk = ~clk;

  mpbus_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .ale_i(ale),
    .rd_ni(rd_n), .wr_ni(wr_n), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_rdata_i(reg_rdata)
  );

  // bench register bank
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
      last_a <= reg_addr;
      last_d <= reg_wdata;
    end
  end

  // {mode, addr, data}
  localparam logic [16:0] VECS [8] = '{
    {1'b0, 8'h00, 8'h5A}, {1'b0, 8'hFF, 8'hA5}, {1'b1, 8'h01, 8'h3C},
    {1'b1, 8'hFE, 8'hC3}, {1'b0, 8'h80, 8'h01}, {1'b1, 8'h7F, 8'h80},
    {1'b0, 8'h42, 8'hFF}, {1'b1, 8'h24, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cycle(input logic m, input logic wr, input logic [7:0] a,
                          input logic [7:0] d, input logic use_cs, input logic ale_stuck,
                          output logic [7:0] rdv, output logic oev);
    @(negedge clk);
    mode = m; cs_n = !use_cs; ale = 1'b1; ad_in = a;
    step(4);
    if (!ale_stuck) ale = 1'b0;
    step(4);
    if (wr) ad_in = d;
    if (m == 1'b0) begin
      if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    end else begin
      wr_n = !wr;
      step(1);
      rd_n = 1'b0;
    end
    step(5);
    rdv = ad_out;
    oev = ad_oe;
    rd_n = 1'b1;
    step(1);
    wr_n = 1'b1;
    step(4);
    cs_n = 1'b1;
    ale = 1'b0;
    step(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic       ov;
    int         n0;
    mode = 0; cs_n = 1; ale = 0; rd_n = 1; wr_n = 1; ad_in = 8'h00;
    rst_n = 1'b0;
    step(3);
    // R6: reset state
    check("R6 reset oe", ad_oe, 0);
    check("R6 reset ad_o", ad_out, 0);
    check("R8 reset we", reg_we, 0);
    rst_n = 1'b1;
    step(3);

    // R1 R2 R3 R8: table of writes
    foreach (VECS[i]) begin
      n0 = we_cnt;
      do_cycle(VECS[i][16], 1'b1, VECS[i][15:8], VECS[i][7:0], 1'b1, 1'b0, rv, ov);
      exp_mem[VECS[i][15:8]] = VECS[i][7:0];
      check(VECS[i][16] ? "R3 write pulses" : "R2 write pulses", we_cnt - n0, 1);
      check("R1 write addr", last_a, VECS[i][15:8]);
      check("R8 write data", last_d, VECS[i][7:0]);
      check("R6 no oe on write", ov, 0);
    end
    // R1 R2 R3 R6 R7: readback with the other mode
    foreach (VECS[i]) begin
      n0 = we_cnt;
      do_cycle(!VECS[i][16], 1'b0, VECS[i][15:8], 8'h00, 1'b1, 1'b0, rv, ov);
      check(VECS[i][16] ? "R2 read oe" : "R3 read oe", ov, 1);
      check("R6 read data", rv, exp_mem[VECS[i][15:8]]);
      check("R7 released", ad_oe, 0);
      check("R8 no write on read", we_cnt - n0, 0);
    end

    // R4: chip select high, write ignored then read shows old value
    n0 = we_cnt;
    do_cycle(1'b0, 1'b1, 8'h42, 8'h99, 1'b0, 1'b0, rv, ov);
    check("R4 no write w/o cs", we_cnt - n0, 0);
    do_cycle(1'b0, 1'b0, 8'h42, 8'h00, 1'b0, 1'b0, rv, ov);
    check("R4 no oe w/o cs", ov, 0);
    do_cycle(1'b0, 1'b0, 8'h42, 8'h00, 1'b1, 1'b0, rv, ov);
    check("R4 old value kept", rv, 8'hFF);

    // R5: address-latch-enable held high
    n0 = we_cnt;
    do_cycle(1'b1, 1'b1, 8'h24, 8'h77, 1'b1, 1'b1, rv, ov);
    check("R5 no write during ale", we_cnt - n0, 0);
    do_cycle(1'b0, 1'b0, 8'h24, 8'h00, 1'b1, 1'b1, rv, ov);
    check("R5 no oe during ale", ov, 0);

    // R3: direction low without data strobe, no write
    n0 = we_cnt;
    @(negedge clk); mode = 1; cs_n = 0; ale = 1; ad_in = 8'h24; step(4);
    ale = 0; step(4); ad_in = 8'h66; wr_n = 0; step(6); wr_n = 1; step(2); cs_n = 1; step(4);
    check("R3 direction alone no write", we_cnt - n0, 0);

    // R7 R8: chip select rises before the strobe ends
    n0 = we_cnt;
    @(negedge clk); mode = 0; cs_n = 0; ale = 1; ad_in = 8'h10; step(4);
    ale = 0; step(4); ad_in = 8'hB7; wr_n = 0; step(5);
    cs_n = 1; step(5);
    check("R8 cs-rise commit", we_cnt - n0, 1);
    wr_n = 1; step(5);
    check("R8 single pulse", we_cnt - n0, 1);
    check("R8 cs-rise data", mem[8'h10], 8'hB7);

    // R8: last bus value is committed
    n0 = we_cnt;
    @(negedge clk); mode = 1; cs_n = 0; ale = 1; ad_in = 8'h11; step(4);
    ale = 0; step(4); ad_in = 8'h01; wr_n = 0; step(1); rd_n = 0; step(4);
    ad_in = 8'hE2; step(4); rd_n = 1; step(5);
    check("R8 last data pulses", we_cnt - n0, 1);
    check("R8 last data", mem[8'h11], 8'hE2);
    wr_n = 1; cs_n = 1; step(4);

    // R7 R9: read latency and release on cs rise with strobe held
    @(negedge clk); mode = 0; cs_n = 0; ale = 1; ad_in = 8'h10; step(4);
    ale = 0; step(4);
    rd_n = 0;
    step(2);
    check("R9 oe not yet", ad_oe, 0);
    step(1);
    check("R9 oe on third edge", ad_oe, 1);
    check("R6 latency data", ad_out, 8'hB7);
    cs_n = 1;
    step(4);
    check("R7 cs rise releases", ad_oe, 0);
    check("R7 bus zero", ad_out, 0);
    rd_n = 1; step(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule